// File: doc/BRIEF.md
# Video Sample Output Formatter

This block is the last digital stage of one channel (luma or chroma) of an 8-bit video digitiser. Each clock it takes one converter result together with an underflow flag and an overflow flag. It drives a registered 8-bit word to the channel's data pins, together with an output-enable. A two-bit code stands for a pin with three levels. That code selects offset-binary coding, two's-complement coding, or a released bus. Samples outside the converter's range are clamped to the nearest end code in whichever coding is active.

Each channel has its own copy of the block and its own format control. The format code travels down the pipeline with its sample, so a change of coding or of enable takes effect on exactly the word that was presented with it. The actual tri-state pad is outside the block: the enable output is meant to drive it.

Top module: `vfmt_out_stage`

## Requirements
- R1: With format code 01 (binary), an in-range sample appears on `data_out` unchanged, with `data_oe` high.
- R2: With format code 00 (two's complement), the output is the binary word with bit 7 inverted and all other bits kept: 0x00 gives 0x80, 0xFF gives 0x7F, 0x5A gives 0xDA.
- R3: Format codes 10 and 11 both drive `data_oe` low.
- R4: A sample with `smp_under` high gives the lowest code regardless of `smp_in`: 0x00 in binary, 0x80 in two's complement.
- R5: A sample with `smp_over` high and `smp_under` low gives the highest code regardless of `smp_in`: 0xFF in binary, 0x7F in two's complement.
- R6: When both flags are high on the same sample, underflow takes priority and the lowest code is produced.
- R7: A synchronous active-high `rst` forces `data_out` to 0x00 and `data_oe` low. Both stay that way until the first sample taken after reset reaches the output.
- R8: While the bus is released, `data_out` still tracks the incoming samples in binary coding, with clamping applied. As a result, the first word after re-enabling is already valid.
- R9: Latency is two clocks. A sample and format code present at rising edge k show on the outputs after rising edge k+1 and not before. Back-to-back samples stream at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 8 | Converter result, offset binary, bit 7 MSB |
| smp_under | input | 1 | Sample is below the lowest step |
| smp_over | input | 1 | Sample is above the highest step |
| fmt_sel | input | 2 | 00 two's complement, 01 binary, 10/11 released bus |
| data_out | output | 8 | Registered coded output word |
| data_oe | output | 1 | Enable for the external data pad drivers |

## Verification
The case of interest is clamping and recoding in the same cycle. Here an overflow or underflow sample arrives together with a change of the format code, so the clamped value must appear in the new coding. The bench provokes this by switching from binary to two's complement on an overflow sample. It also switches from two's complement to binary on an underflow sample. It also re-enables the bus on an out-of-range sample. In each case the bench judges the one output word two edges later against the end code of the newly selected coding.

// File: rtl/vfmt_pkg.sv
package vfmt_pkg;

    parameter int VF_DW = 8;

    typedef enum logic [1:0] {
        FMT_TWOS = 2'b00,
        FMT_BIN  = 2'b01,
        FMT_OFFA = 2'b10,
        FMT_OFFB = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [VF_DW-1:0] sample;
        logic             udf;
        logic             ovf;
        fmt_e             fmt;
    } stg_in_t;

    typedef struct packed {
        logic [VF_DW-1:0] word;
        logic             oe;
    } stg_out_t;

    typedef struct packed {
        stg_in_t  s1;
        stg_out_t s2;
    } pipe_t;

endpackage

// File: rtl/vfmt_clip.sv
module vfmt_clip #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         below,
    input  logic         above,
    output logic [W-1:0] clipped
);
    // Underflow outranks overflow when both are flagged.
    always_comb begin
        if (below) begin
            clipped = '0;
        end else if (above) begin
            clipped = '1;
        end else begin
            clipped = raw;
        end
    end
endmodule

// File: rtl/vfmt_encode.sv
module vfmt_encode
    import vfmt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] clipped,
    input  fmt_e         fmt,
    output logic [W-1:0] word,
    output logic         oe
);
    logic flip_msb;

    always_comb begin
        flip_msb = (fmt == FMT_TWOS);
        oe       = (fmt == FMT_TWOS) || (fmt == FMT_BIN);
    end

    // Offset binary to two's complement only touches the top bit.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b == W - 1) begin : g_msb
            assign word[b] = clipped[b] ^ flip_msb;
        end else begin : g_low
            assign word[b] = clipped[b];
        end
    end
endmodule

// File: rtl/vfmt_out_stage.sv
module vfmt_out_stage
    import vfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [VF_DW-1:0] smp_in,
    input  logic             smp_under,
    input  logic             smp_over,
    input  logic [1:0]       fmt_sel,
    output logic [VF_DW-1:0] data_out,
    output logic             data_oe
);
    localparam int W = VF_DW;
    localparam pipe_t RST_VAL = '{
        s1: '{sample: '0, udf: 1'b0, ovf: 1'b0, fmt: FMT_OFFA},
        s2: '{word: '0, oe: 1'b0}
    };

    pipe_t r_d;
    pipe_t r_q;

    logic [W-1:0] clip_w;
    logic [W-1:0] enc_word;
    logic         enc_oe;

    vfmt_clip #(.W(W)) u_clip (
        .raw     (r_q.s1.sample),
        .below   (r_q.s1.udf),
        .above   (r_q.s1.ovf),
        .clipped (clip_w)
    );

    vfmt_encode #(.W(W)) u_enc (
        .clipped (clip_w),
        .fmt     (r_q.s1.fmt),
        .word    (enc_word),
        .oe      (enc_oe)
    );

    always_comb begin
        r_d           = r_q;
        r_d.s1.sample = smp_in;
        r_d.s1.udf    = smp_under;
        r_d.s1.ovf    = smp_over;
        r_d.s1.fmt    = fmt_e'(fmt_sel);
        r_d.s2.word   = enc_word;
        r_d.s2.oe     = enc_oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_out = r_q.s2.word;
    assign data_oe  = r_q.s2.oe;

    AST_BIN_PASS: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.fmt == FMT_BIN && !r_q.s1.udf && !r_q.s1.ovf)
        |=> (data_oe && data_out == $past(r_q.s1.sample))); // R1

    AST_TWOS_MAP: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.fmt == FMT_TWOS && !r_q.s1.udf && !r_q.s1.ovf)
        |=> (data_oe && data_out == {~$past(r_q.s1.sample[W-1]), $past(r_q.s1.sample[W-2:0])})); // R2

    AST_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.fmt[1]) |=> !data_oe); // R3

    AST_UNDER_LOW: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.udf && r_q.s1.fmt == FMT_TWOS) |=> (data_out == {1'b1, {(W-1){1'b0}}})); // R4

    AST_OVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.ovf && !r_q.s1.udf && r_q.s1.fmt == FMT_BIN) |=> (data_out == '1)); // R5

    AST_BOTH_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.udf && r_q.s1.ovf && r_q.s1.fmt != FMT_TWOS) |=> (data_out == '0)); // R6

    AST_OFF_TRACK: assert property (@(posedge clk) disable iff (rst)
        (r_q.s1.fmt[1] && !r_q.s1.udf && !r_q.s1.ovf) |=> (data_out == $past(r_q.s1.sample))); // R8
endmodule

// File: tb/sim_vfmt_out_stage.sv
module sim_vfmt_out_stage;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] smp_in;
    logic       smp_under;
    logic       smp_over;
    logic [1:0] fmt_sel;
    logic [7:0] data_out;
    logic       data_oe;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    vfmt_out_stage u0 (
        .clk       (clk),
        .rst       (rst),
        .smp_in    (smp_in),
        .smp_under (smp_under),
        .smp_over  (smp_over),
        .fmt_sel   (fmt_sel),
        .data_out  (data_out),
        .data_oe   (data_oe)
    );

    task automatic check(input string req, input logic eoe, input logic [7:0] ew);
        total++;
        if (data_oe !== eoe || data_out !== ew) begin
            bad++;
            $display("FAIL %s: got oe=%0b data=%02h expected oe=%0b data=%02h",
                     req, data_oe, data_out, eoe, ew);
        end
    endtask

    task automatic put(input logic [7:0] s, input logic u, input logic o, input logic [1:0] f);
        smp_in = s; smp_under = u; smp_over = o; fmt_sel = f;
    endtask

    // Drive at a falling edge; result is visible two falling edges later.
    task automatic run(input string req, input logic [7:0] s, input logic u, input logic o,
                       input logic [1:0] f, input logic eoe, input logic [7:0] ew);
        put(s, u, o, f);
        @(negedge clk);
        @(negedge clk);
        check(req, eoe, ew);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        put(8'hA5, 1'b0, 1'b0, 2'b01);
        repeat (3) @(negedge clk);
        check("R7 in reset", 1'b0, 8'h00);
        rst = 1'b0;
        put(8'h33, 1'b0, 1'b0, 2'b01);
        @(negedge clk);
        check("R7 first edge after reset", 1'b0, 8'h00);
        @(negedge clk);
        check("R7 first sample after reset", 1'b1, 8'h33);
    endtask

    task automatic t_binary();
        run("R1 bin 00", 8'h00, 1'b0, 1'b0, 2'b01, 1'b1, 8'h00);
        run("R1 bin 5A", 8'h5A, 1'b0, 1'b0, 2'b01, 1'b1, 8'h5A);
        run("R1 bin FF", 8'hFF, 1'b0, 1'b0, 2'b01, 1'b1, 8'hFF);
    endtask

    task automatic t_twos();
        run("R2 twos 00", 8'h00, 1'b0, 1'b0, 2'b00, 1'b1, 8'h80);
        run("R2 twos FF", 8'hFF, 1'b0, 1'b0, 2'b00, 1'b1, 8'h7F);
        run("R2 twos 5A", 8'h5A, 1'b0, 1'b0, 2'b00, 1'b1, 8'hDA);
    endtask

    task automatic t_clamp();
        run("R4 under bin", 8'h77, 1'b1, 1'b0, 2'b01, 1'b1, 8'h00);
        run("R4 under twos", 8'h77, 1'b1, 1'b0, 2'b00, 1'b1, 8'h80);
        run("R5 over bin", 8'h12, 1'b0, 1'b1, 2'b01, 1'b1, 8'hFF);
        run("R5 over twos", 8'h12, 1'b0, 1'b1, 2'b00, 1'b1, 8'h7F);
        run("R6 both flags bin", 8'h40, 1'b1, 1'b1, 2'b01, 1'b1, 8'h00);
        run("R6 both flags twos", 8'h40, 1'b1, 1'b1, 2'b00, 1'b1, 8'h80);
    endtask

    task automatic t_release();
        run("R3 code 10", 8'h21, 1'b0, 1'b0, 2'b10, 1'b0, 8'h21);
        run("R3 code 11", 8'h22, 1'b0, 1'b0, 2'b11, 1'b0, 8'h22);
        run("R8 off tracks binary", 8'hC3, 1'b0, 1'b0, 2'b10, 1'b0, 8'hC3);
        run("R8 off clamps over", 8'h05, 1'b0, 1'b1, 2'b11, 1'b0, 8'hFF);
        run("R8 first word on re-enable", 8'h9C, 1'b0, 1'b0, 2'b00, 1'b1, 8'h1C);
    endtask

    task automatic t_latency();
        run("R9 settle", 8'h10, 1'b0, 1'b0, 2'b01, 1'b1, 8'h10);
        put(8'hE1, 1'b0, 1'b0, 2'b01);
        @(negedge clk);
        check("R9 not yet after one edge", 1'b1, 8'h10);
        put(8'hE2, 1'b0, 1'b0, 2'b00);
        @(negedge clk);
        check("R9 stream word 1", 1'b1, 8'hE1);
        put(8'hE3, 1'b0, 1'b0, 2'b10);
        @(negedge clk);
        check("R9 stream word 2", 1'b1, 8'h62);
        put(8'hE4, 1'b0, 1'b0, 2'b01);
        @(negedge clk);
        check("R9 stream word 3", 1'b0, 8'hE3);
        @(negedge clk);
        check("R9 stream word 4", 1'b1, 8'hE4);
    endtask

    // Clamping and recoding land in the same output word.
    task automatic t_collide();
        run("R5 over with switch to twos", 8'h01, 1'b0, 1'b1, 2'b00, 1'b1, 8'h7F);
        run("R4 under with switch to bin", 8'hF0, 1'b1, 1'b0, 2'b01, 1'b1, 8'h00);
        run("R3 off pre-collide", 8'h44, 1'b0, 1'b0, 2'b10, 1'b0, 8'h44);
        run("R5 over on re-enable twos", 8'h44, 1'b0, 1'b1, 2'b00, 1'b1, 8'h7F);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        put(8'h00, 1'b0, 1'b0, 2'b10);
        @(negedge clk);
        t_reset();
        t_binary();
        t_twos();
        t_clamp();
        t_release();
        t_latency();
        t_collide();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule